// File: doc/BRIEF.md
# Byte-Lane Load/Store Data Memory

This block is the data memory of a 32-bit load/store core. The memory itself selects the byte lanes and widens the result, so no alignment or extension unit is needed in front of it. The core passes the 3-bit width/sign field of the load or store instruction straight in as the access mode. It also passes a byte address, the store data and a write enable. The block returns a full 32-bit read word with sign or zero extension already applied.

Storage is a flat array of bytes. Wider accesses use the bytes at consecutive addresses, starting at the given address, in little-endian order. Stores take effect on the rising clock edge and write only the bytes their width covers. Reads are combinational. A read that shares a cycle with a write to the same location returns the contents from before that write. A halfword or word access that is not naturally aligned raises a flag, and the write it carries is dropped.

Top module: `ls_data_mem`

## Requirements
- R1: A word store (mode 010) at address A writes wdata[7:0] to byte A, wdata[15:8] to A+1, wdata[23:16] to A+2 and wdata[31:24] to A+3. A word load at A returns those four bytes reassembled in the same order.
- R2: A mode 000 load returns the byte at A in bits 7:0 and copies its bit 7 into bits 31:8.
- R3: A mode 100 load returns the byte at A in bits 7:0 with bits 31:8 zero.
- R4: A mode 001 load returns the halfword {byte A+1, byte A} in bits 15:0 with its bit 15 copied into bits 31:16. A mode 101 load returns the same halfword with bits 31:16 zero.
- R5: A byte store (mode 000) changes only byte A. A halfword store (mode 001) changes only bytes A and A+1, taking wdata[7:0] and wdata[15:8].
- R6: `misaligned` is high in the same cycle when a halfword mode (001 or 101) has A[0]=1, or when mode 010 has A[1:0]≠00. Byte modes never raise it. While it is high, a store changes no byte.
- R7: Modes 011, 110 and 111 read as zero, hold `misaligned` low, and change no byte when written.
- R8: In a cycle where a store is presented, the read output shows the contents before the store. The new contents appear after the rising edge.
- R9: Stores presented while `rst` is high change no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores take effect on the rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks stores |
| addr | input | 32 | Byte address (low bits index the storage) |
| wdata | input | 32 | Store data, lane 0 in bits 7:0 |
| we | input | 1 | Store request |
| mode | input | 3 | Access width and signedness code |
| rdata | output | 32 | Extended read word |
| misaligned | output | 1 | Alignment violation for the current mode and address |

## Verification
Read data and the misalignment flag are combinational. The bench therefore drives new inputs at the falling edge and samples them a quarter period later, before the next rising edge. A store takes effect on the rising edge that follows its presentation. Its result is checked from the next falling edge on, after the enable has been dropped. The same-cycle check samples while the store is still presented and expects the old word, then samples again after the edge and expects the new one.

// File: rtl/ls_data_mem_pkg.sv
package ls_data_mem_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_BITS  = WORD_BYTES * 8;

  typedef enum logic [2:0] {
    MODE_SB = 3'b000,
    MODE_SH = 3'b001,
    MODE_SW = 3'b010,
    MODE_UB = 3'b100,
    MODE_UH = 3'b101
  } acc_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;
endpackage

// File: rtl/ls_access_decode.sv
module ls_access_decode
  import ls_data_mem_pkg::*;
(
  input  logic [2:0]            mode,
  input  logic [1:0]            addr_lo,
  output acc_size_e             size,
  output logic                  sign_ext,
  output logic                  misalign,
  output logic [WORD_BYTES-1:0] lane_en
);
  always_comb begin
    size     = SZ_NONE;
    sign_ext = 1'b0;
    unique case (mode)
      MODE_SB: begin size = SZ_BYTE; sign_ext = 1'b1; end
      MODE_SH: begin size = SZ_HALF; sign_ext = 1'b1; end
      MODE_SW:       size = SZ_WORD;
      MODE_UB:       size = SZ_BYTE;
      MODE_UH:       size = SZ_HALF;
      default:       size = SZ_NONE;
    endcase
  end

  always_comb begin
    misalign = 1'b0;
    lane_en  = '0;
    case (size)
      SZ_BYTE: lane_en = 4'b0001;
      SZ_HALF: begin lane_en = 4'b0011; misalign = addr_lo[0]; end
      SZ_WORD: begin lane_en = 4'b1111; misalign = |addr_lo; end
      default: lane_en = '0;
    endcase
  end
endmodule

// File: rtl/ls_byte_store.sv
module ls_byte_store
  import ls_data_mem_pkg::*;
#(
  parameter int DEPTH_BYTES = 1024,
  localparam int IDX_W = $clog2(DEPTH_BYTES)
) (
  input  logic                  clk,
  input  logic                  wr_go,
  input  logic [IDX_W-1:0]      base,
  input  logic [WORD_BYTES-1:0] lane_en,
  input  logic [WORD_BITS-1:0]  wdata,
  output logic [WORD_BITS-1:0]  rd_bytes
);
  logic [7:0] mem [DEPTH_BYTES];
  logic [IDX_W-1:0] idx [WORD_BYTES];

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign idx[g] = base + IDX_W'(g);
    assign rd_bytes[8*g +: 8] = mem[idx[g]];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WORD_BYTES; i++) begin
      if (wr_go && lane_en[i]) mem[idx[i]] <= wdata[8*i +: 8];
    end
  end
endmodule

// File: rtl/ls_load_format.sv
module ls_load_format
  import ls_data_mem_pkg::*;
(
  input  logic [WORD_BITS-1:0] raw,
  input  acc_size_e            size,
  input  logic                 sign_ext,
  output logic [WORD_BITS-1:0] rdata
);
  logic fill_b, fill_h;
  assign fill_b = sign_ext & raw[7];
  assign fill_h = sign_ext & raw[15];

  always_comb begin
    case (size)
      SZ_BYTE: rdata = {{(WORD_BITS-8){fill_b}}, raw[7:0]};
      SZ_HALF: rdata = {{(WORD_BITS-16){fill_h}}, raw[15:0]};
      SZ_WORD: rdata = raw;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ls_data_mem.sv
module ls_data_mem
  import ls_data_mem_pkg::*;
#(
  parameter int DEPTH_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  input  logic        we,
  input  logic [2:0]  mode,
  output logic [31:0] rdata,
  output logic        misaligned
);
  localparam int IDX_W = $clog2(DEPTH_BYTES);

  acc_size_e             size;
  logic                  sign_ext;
  logic [WORD_BYTES-1:0] lane_en;
  logic [WORD_BITS-1:0]  raw;
  logic                  wr_go;

  ls_access_decode u_dec (
    .mode     (mode),
    .addr_lo  (addr[1:0]),
    .size     (size),
    .sign_ext (sign_ext),
    .misalign (misaligned),
    .lane_en  (lane_en)
  );

  assign wr_go = we & ~rst & ~misaligned;

  ls_byte_store #(.DEPTH_BYTES(DEPTH_BYTES)) u_store (
    .clk      (clk),
    .wr_go    (wr_go),
    .base     (addr[IDX_W-1:0]),
    .lane_en  (lane_en),
    .wdata    (wdata),
    .rd_bytes (raw)
  );

  ls_load_format u_fmt (
    .raw      (raw),
    .size     (size),
    .sign_ext (sign_ext),
    .rdata    (rdata)
  );
endmodule

// File: rtl/ls_data_mem_chk.sv
module ls_data_mem_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] addr,
  input logic [2:0]  mode,
  input logic [31:0] rdata,
  input logic        misaligned
);
  AST_SB_EXTENDS: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b000) |-> (rdata[31:8] == {24{rdata[7]}}));              // R2
  AST_UB_ZERO_TOP: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b100) |-> (rdata[31:8] == 24'h0));                       // R3
  AST_UH_ZERO_TOP: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b101) |-> (rdata[31:16] == 16'h0));                      // R4
  AST_HALF_ODD_FLAG: assert property (@(posedge clk) disable iff (rst)
    ((mode == 3'b001 || mode == 3'b101) && addr[0]) |-> misaligned);    // R6
  AST_BYTE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b000 || mode == 3'b100) |-> !misaligned);                // R6
  AST_UNUSED_MODE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b011 || mode[2:1] == 2'b11) |-> (rdata == 32'h0 && !misaligned)); // R7
  AST_FLAG_ONLY_WIDE: assert property (@(posedge clk) disable iff (rst)
    (misaligned && $stable(addr)) |-> (addr[1:0] != 2'b00));            // R6
endmodule

bind ls_data_mem ls_data_mem_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .addr       (addr),
  .mode       (mode),
  .rdata      (rdata),
  .misaligned (misaligned)
);

// File: tb/ls_data_mem_bench.sv
module ls_data_mem_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] addr = '0, wdata = '0;
  logic we = 1'b0;
  logic [2:0] mode = 3'b011;
  logic [31:0] rdata;
  logic misaligned;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  ls_data_mem u_ls_data_mem (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
    .mode(mode), .rdata(rdata), .misaligned(misaligned)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic store(input logic [31:0] a, input logic [2:0] m, input logic [31:0] d);
    @(negedge clk);
    addr = a; mode = m; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic load(input logic [31:0] a, input logic [2:0] m, output logic [31:0] v);
    @(negedge clk);
    addr = a; mode = m; we = 1'b0;
    #5 v = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    #5 chk("R7 reset rdata", rdata, 32'h0);
    chk("R6 reset flag", {31'h0, misaligned}, 32'h0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    store(32'h40, 3'b010, 32'h01020304);
    @(negedge clk); rst = 1'b1;
    store(32'h40, 3'b010, 32'hFFFFFFFF);
    rst = 1'b0;
    load(32'h40, 3'b010, v); chk("R9 write during reset", v, 32'h01020304);
  endtask

  task automatic t_widths();
    logic [31:0] v;
    store(32'h100, 3'b010, 32'h8899AABB);
    load(32'h100, 3'b010, v); chk("R1 word", v, 32'h8899AABB);
    load(32'h100, 3'b100, v); chk("R1 R3 lane0 ub", v, 32'h000000BB);
    load(32'h103, 3'b100, v); chk("R1 R3 lane3 ub", v, 32'h00000088);
    load(32'h100, 3'b000, v); chk("R2 sb neg", v, 32'hFFFFFFBB);
    load(32'h102, 3'b001, v); chk("R4 sh neg", v, 32'hFFFF8899);
    load(32'h102, 3'b101, v); chk("R4 uh", v, 32'h00008899);
    store(32'h104, 3'b010, 32'h7F017E02);
    load(32'h104, 3'b000, v); chk("R2 sb pos", v, 32'h00000002);
    load(32'h106, 3'b001, v); chk("R4 sh pos", v, 32'h00007F01);
  endtask

  task automatic t_partial();
    logic [31:0] v;
    store(32'h101, 3'b000, 32'h12345655);
    load(32'h100, 3'b010, v); chk("R5 byte store", v, 32'h889955BB);
    store(32'h102, 3'b001, 32'hABCD1234);
    load(32'h100, 3'b010, v); chk("R5 half store", v, 32'h123455BB);
  endtask

  task automatic t_misalign();
    logic [31:0] v;
    load(32'h101, 3'b001, v); chk("R6 half odd flag", {31'h0, misaligned}, 32'h1);
    load(32'h102, 3'b010, v); chk("R6 word flag", {31'h0, misaligned}, 32'h1);
    load(32'h103, 3'b000, v); chk("R6 byte no flag", {31'h0, misaligned}, 32'h0);
    load(32'h104, 3'b010, v); chk("R6 aligned word", {31'h0, misaligned}, 32'h0);
    store(32'h101, 3'b001, 32'hEEEEEEEE);
    store(32'h101, 3'b010, 32'hDDDDDDDD);
    load(32'h100, 3'b010, v); chk("R6 blocked store", v, 32'h123455BB);
  endtask

  task automatic t_unused();
    logic [31:0] v;
    for (int k = 0; k < 3; k++) begin
      logic [2:0] m;
      m = (k == 0) ? 3'b011 : (k == 1) ? 3'b110 : 3'b111;
      load(32'h100, m, v); chk("R7 unused mode reads zero", v, 32'h0);
      chk("R7 unused mode flag", {31'h0, misaligned}, 32'h0);
      store(32'h100, m, 32'h0BADF00D);
    end
    load(32'h100, 3'b010, v); chk("R7 unused mode no write", v, 32'h123455BB);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    store(32'h108, 3'b010, 32'h00000000);
    @(negedge clk);
    addr = 32'h108; mode = 3'b010; wdata = 32'hCAFEF00D; we = 1'b1;
    #5 chk("R8 old data during store", rdata, 32'h00000000);
    @(negedge clk);
    we = 1'b0;
    #5 chk("R8 new data after edge", rdata, 32'hCAFEF00D);
    load(32'h108, 3'b010, v); chk("R8 held", v, 32'hCAFEF00D);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_widths();
        t_partial();
        t_misalign();
        t_unused();
        t_same_cycle();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog got=timeout exp=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule